// File: doc/BRIEF.md
# Segmented Converter Front-End Register and Decoder

This block is the digital side of a 14-bit current-steering converter. The converter uses a split architecture. The ten low-order bits of the sample steer a binary-weighted ladder. The four high-order bits choose how many equal-weight current cells are switched on, and the block decodes them into a 15-wide thermometer vector.

Each sample passes through two register stages. A capture stage takes the word on a rising clock edge. An update stage then drives the ladder field and the cell enables from the same edge, so no cell moves ahead of the rest. The update stage also holds two integer models in LSB units: one for the true output current and one for the complementary output current. A one-cycle flag marks every update that changes the segment field. Those updates are the points where a whole current cell switches, at every multiple of 1024.

Top module: `dac_front_end`

## Requirements
- R1: While `rst` is high at a rising edge, both stages clear. After that edge, `ladder_o` is 0, `cell_en_o` is 0, `iout_o` is 0, `iout_n_o` is 16383 and `seg_step_o` is 0.
- R2: A word on `code_i` at rising edge n appears on every output after rising edge n+1: two edges of latency, one per stage.
- R3: `ladder_o` equals bits 9..0 of the word, unchanged in value and order.
- R4: Bit k of `cell_en_o` (k = 0..14) is 1 exactly when the unsigned value of word bits 13..10 is greater than k. The vector therefore only ever holds a run of ones that starts at bit 0.
- R5: `iout_o` equals the word and `iout_n_o` equals 16383 minus the word, so their sum is always 16383.
- R6: The end codes behave as follows. Word 0x3FFF gives 16383 true, 0 complementary and all 15 cells on. Word 0x2000 gives 8192 true, 8191 complementary and cells 0..7 on. Word 0 gives 0 true, 16383 complementary and no cells on.
- R7: `seg_step_o` is high for one cycle after an update whose bits 13..10 differ from those of the previous update. Examples: 1023 followed by 1024 raises it, and 1024 followed by 2047 does not.
- R8: On every cycle, `iout_o` equals 1024 times the number of set bits in `cell_en_o`, plus `ladder_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 14 | Sample word; bit 13 is the most significant |
| ladder_o | output | 10 | Binary field for the ladder |
| cell_en_o | output | 15 | Thermometer enables for the equal-weight cells |
| iout_o | output | 14 | True output current model, in LSB units |
| iout_n_o | output | 14 | Complementary output current model, in LSB units |
| seg_step_o | output | 1 | One-cycle flag for a segment-field change |

## Verification
Several properties are checked by assertions on every cycle:
- the enables form a contiguous run of ones from bit 0;
- the two current models sum to full scale minus one;
- the true model matches the cell count times 1024 plus the ladder field;
- the output equals the input from two edges earlier;
- the segment-step flag is high only after an actual change in the segment field.

Other behaviours only the bench scenarios can show:
- the reset values;
- the exact end codes;
- the flag firing, rather than staying silent, at the 1023-to-1024 boundary and at other multiples of 1024;
- the flag staying low for moves within one segment.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  parameter int unsigned BIN_W = 10;
  parameter int unsigned SEG_W = 4;
  localparam int unsigned CODE_W = BIN_W + SEG_W;
  localparam int unsigned N_CELLS = (1 << SEG_W) - 1;
endpackage

// File: rtl/dac_fe_capture.sv
module dac_fe_capture #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/dac_fe_therm.sv
module dac_fe_therm #(
  parameter int unsigned SEG_W = 4,
  localparam int unsigned N = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0] field_i,
  output logic [N-1:0]     en_o
);
  for (genvar k = 0; k < N; k++) begin : g_cell
    assign en_o[k] = (field_i > SEG_W'(k));
  end
endmodule

// File: rtl/dac_fe_update.sv
module dac_fe_update #(
  parameter int unsigned BIN_W = 10,
  parameter int unsigned SEG_W = 4,
  localparam int unsigned CW = BIN_W + SEG_W,
  localparam int unsigned N = (1 << SEG_W) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] word_i,
  input  logic [N-1:0]  en_i,
  output logic [BIN_W-1:0] ladder_o,
  output logic [N-1:0]  cell_en_o,
  output logic [CW-1:0] iout_o,
  output logic [CW-1:0] iout_n_o,
  output logic          seg_step_o
);
  localparam logic [CW-1:0] FULL = '1;

  logic [SEG_W-1:0] seg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ladder_o   <= '0;
      cell_en_o  <= '0;
      iout_o     <= '0;
      iout_n_o   <= FULL;
      seg_q      <= '0;
      seg_step_o <= 1'b0;
    end else begin
      ladder_o   <= word_i[BIN_W-1:0];
      cell_en_o  <= en_i;
      iout_o     <= word_i;
      iout_n_o   <= FULL - word_i;
      seg_q      <= word_i[CW-1:BIN_W];
      seg_step_o <= (word_i[CW-1:BIN_W] != seg_q);
    end
  end

  // R4: the enables hold only a run of ones starting at bit 0
  p_therm_contig_r4: assert property (@(posedge clk) disable iff (rst)
    ((cell_en_o & (cell_en_o + N'(1))) == '0));

  // R5: the true and complementary models sum to full scale minus one
  p_sum_full_r5: assert property (@(posedge clk) disable iff (rst)
    ((CW+1)'(iout_o) + (CW+1)'(iout_n_o) == (CW+1)'(FULL)));

  // R8: the true model matches cells times 1024 plus the ladder field
  p_model_match_r8: assert property (@(posedge clk) disable iff (rst)
    (((CW'($countones(cell_en_o))) << BIN_W) + CW'(ladder_o) == iout_o));

  // R7: the flag is raised only when the segment field moved
  p_step_real_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(seg_step_o) |-> (iout_o[CW-1:BIN_W] != $past(iout_o[CW-1:BIN_W])));
endmodule

// File: rtl/dac_front_end.sv
module dac_front_end #(
  parameter int unsigned BIN_W = dac_fe_pkg::BIN_W,
  parameter int unsigned SEG_W = dac_fe_pkg::SEG_W,
  localparam int unsigned CW = BIN_W + SEG_W,
  localparam int unsigned N = (1 << SEG_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    code_i,
  output logic [BIN_W-1:0] ladder_o,
  output logic [N-1:0]     cell_en_o,
  output logic [CW-1:0]    iout_o,
  output logic [CW-1:0]    iout_n_o,
  output logic             seg_step_o
);
  logic [CW-1:0] held;
  logic [N-1:0]  en_dec;

  dac_fe_capture #(.W(CW)) u_capture (
    .clk(clk), .rst(rst), .d_i(code_i), .q_o(held)
  );

  dac_fe_therm #(.SEG_W(SEG_W)) u_therm (
    .field_i(held[CW-1:BIN_W]), .en_o(en_dec)
  );

  dac_fe_update #(.BIN_W(BIN_W), .SEG_W(SEG_W)) u_update (
    .clk(clk), .rst(rst), .word_i(held), .en_i(en_dec),
    .ladder_o(ladder_o), .cell_en_o(cell_en_o), .iout_o(iout_o),
    .iout_n_o(iout_n_o), .seg_step_o(seg_step_o)
  );

  // R2: the output word is the input word from two edges earlier
  p_two_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (iout_o == $past(code_i, 2)));

  // R3: the ladder field is the low part of the output word
  p_ladder_low_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (ladder_o == $past(code_i[BIN_W-1:0], 2)));
endmodule

// File: tb/dac_front_end_tb.sv
module dac_front_end_tb;
  localparam int BW = 10;
  localparam int SW = 4;
  localparam int CW = 14;
  localparam int N = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] code_i = '0;
  logic [BW-1:0] ladder_o;
  logic [N-1:0] cell_en_o;
  logic [CW-1:0] iout_o, iout_n_o;
  logic seg_step_o;

  int n_checks = 0;
  int n_fail = 0;
  int p1 = 0, p2 = 0, p3 = 0;

  always #4 clk = ~clk;

  dac_front_end u_dut (
    .clk(clk), .rst(rst), .code_i(code_i), .ladder_o(ladder_o),
    .cell_en_o(cell_en_o), .iout_o(iout_o), .iout_n_o(iout_n_o),
    .seg_step_o(seg_step_o)
  );

  function automatic logic [N-1:0] exp_cells(int code);
    logic [N-1:0] v = '0;
    for (int k = 0; k < N; k++) v[k] = ((code >> BW) > k);
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(int w, int prevw);
    chk("R3 ladder", int'(ladder_o), w & 1023);
    chk("R4 cells", int'(cell_en_o), int'(exp_cells(w)));
    chk("R5 true", int'(iout_o), w);
    chk("R5 comp", int'(iout_n_o), 16383 - w);
    chk("R7 step", int'(seg_step_o), ((w >> BW) != (prevw >> BW)) ? 1 : 0);
    chk("R8 model", int'(iout_o), $countones(cell_en_o) * 1024 + int'(ladder_o));
  endtask

  // R2: the output at each falling edge reflects the input driven two falling edges before
  task automatic step(int v);
    @(negedge clk);
    check_all(p2, p3);
    code_i = CW'(v);
    p3 = p2; p2 = p1; p1 = v;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    int seed;
    int v;
    seed = 7;
    void'($urandom(seed));
    code_i = 14'h1555;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ladder", int'(ladder_o), 0);
    chk("R1 cells", int'(cell_en_o), 0);
    chk("R1 true", int'(iout_o), 0);
    chk("R1 comp", int'(iout_n_o), 16383);
    chk("R1 step", int'(seg_step_o), 0);
    code_i = '0;
    @(negedge clk);
    rst = 1'b0;
    // R6 corner codes; R7 boundaries
    step(16383); step(0); step(8192); step(0);
    step(1023); step(1024); step(2047); step(2048); step(3071); step(3072);
    step(16383); step(16383); step(0);
    for (int i = 0; i < 400; i++) begin
      v = int'($urandom % 16384);
      if (i % 5 == 0) v = (v & 16'h3C00) | ((i % 10 == 0) ? 1023 : 0);
      step(v);
    end
    step(0); step(0); step(0);
    // R6 explicit: drive 0x2000 and read back after two edges
    @(negedge clk); code_i = 14'h2000;
    @(negedge clk); @(negedge clk);
    chk("R6 half true", int'(iout_o), 8192);
    chk("R6 half comp", int'(iout_n_o), 8191);
    chk("R6 half cells", int'(cell_en_o), 8'hFF);
    code_i = 14'h3FFF;
    @(negedge clk); @(negedge clk);
    chk("R6 top true", int'(iout_o), 16383);
    chk("R6 top comp", int'(iout_n_o), 0);
    chk("R6 top cells", int'(cell_en_o), 32767);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule